// File: doc/BRIEF.md
# Multi-Mode Funnel Shifter

A combinational N-bit shifter that produces logical, arithmetic and rotating shifts in both directions from a single right-shifting funnel. From the operand, a fill pattern chosen by the mode, and the operand bits themselves, the block forms an intermediate word of 2N-1 bits. It then extracts an N-bit window from that word, starting at a bit offset.

For right-going modes the offset is the shift amount. For left-going modes it is the bitwise complement of the shift amount, which equals N-1-k, so no subtracter is needed. The window extraction is a chain of log2(N) stages of 2-input multiplexers. Stage s moves the word down by 2^s bits when offset bit s is set, and each stage is narrower than the one before.

The block is intended for an integer datapath that needs all six shift styles with a single selector structure. The shift amount always lies in 0..N-1. Mode codes that are not defined pass the operand through unchanged.

Top module: `fsh_funnel`

## Requirements
- R1: Mode 3'b000 (logical right) gives y = a >> k, with zeros entering at the most significant end.
- R2: Mode 3'b001 (logical left) gives y = a << k, with zeros entering at the least significant end.
- R3: Mode 3'b010 (arithmetic right) gives y = a >>> k with a taken as signed, so bit N-1 of a fills the vacated upper positions.
- R4: Mode 3'b011 (arithmetic left) gives exactly the same result as mode 3'b001 for every a and k.
- R5: Mode 3'b100 (rotate right) gives y[i] = a[(i+k) mod N] for every bit i.
- R6: Mode 3'b101 (rotate left) gives y[i] = a[(i-k) mod N] for every bit i.
- R7: A shift amount of 0 returns a unchanged in every mode.
- R8: Mode codes 3'b110 and 3'b111 return a unchanged for every shift amount.
- R9: In both rotate modes, the number of ones in y equals the number of ones in a.
- R10: The output is a pure function of the present inputs and is valid in the same cycle the inputs change, with no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | N | Operand to be shifted |
| shamt | input | $clog2(N) | Shift amount, 0 to N-1 |
| mode | input | 3 | Shift style selector (codes given in R1 to R8) |
| y_out | output | N | Shifted or rotated result |

## Verification
The hardest cases to reach are where the fill pattern meets the moved operand bits. These occur at the largest shift amounts, where only one operand bit is left in the window, and at a shift of zero, where the offset for the left modes is N-1 and the whole window comes from the upper part of the intermediate word. The stimulus therefore sweeps every mode code, including the two undefined ones, against every shift amount from 0 to N-1. It uses operands chosen so that a lost or misplaced fill bit is visible: a single top bit, a single bottom bit, all ones, all zeros, alternating patterns and a set of random words. For the rotate modes it also compares population counts.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

  localparam logic [2:0] FSH_LSR = 3'b000;
  localparam logic [2:0] FSH_LSL = 3'b001;
  localparam logic [2:0] FSH_ASR = 3'b010;
  localparam logic [2:0] FSH_ASL = 3'b011;
  localparam logic [2:0] FSH_ROR = 3'b100;
  localparam logic [2:0] FSH_ROL = 3'b101;

  // left-going styles use the complemented shift amount as window offset
  function automatic logic fsh_is_left(input logic [2:0] m);
    return (m == FSH_LSL) || (m == FSH_ASL) || (m == FSH_ROL);
  endfunction

  function automatic logic fsh_is_rotate(input logic [2:0] m);
    return (m == FSH_ROR) || (m == FSH_ROL);
  endfunction

  function automatic logic fsh_is_defined(input logic [2:0] m);
    return m <= FSH_ROL;
  endfunction

endpackage

// File: rtl/fsh_zbuild.sv
module fsh_zbuild #(
  parameter int N  = 32,
  parameter int KW = $clog2(N)
) (
  input  logic [N-1:0]   a,
  input  logic [KW-1:0]  k,
  input  logic [2:0]     mode,
  output logic [2*N-2:0] z,
  output logic [KW-1:0]  offset
);
  import fsh_pkg::*;

  logic [N-2:0] upper_f;
  logic         mid_b;
  logic [N-2:0] lower_f;

  always_comb begin
    upper_f = '0;
    mid_b   = a[N-1];
    lower_f = a[N-2:0];
    offset  = k;
    case (mode)
      FSH_LSR: ;
      FSH_ASR: upper_f = {(N-1){a[N-1]}};
      FSH_ROR: upper_f = a[N-2:0];
      FSH_LSL, FSH_ASL: begin
        upper_f = a[N-1:1];
        mid_b   = a[0];
        lower_f = '0;
        offset  = ~k;
      end
      FSH_ROL: begin
        upper_f = a[N-1:1];
        mid_b   = a[0];
        lower_f = a[N-1:1];
        offset  = ~k;
      end
      default: offset = '0;
    endcase
  end

  assign z = {upper_f, mid_b, lower_f};

  // left offsets must land the window so that k + offset spans N-1 bits
  always_comb begin
    if (fsh_is_left(mode))
      assert_left_offset_R2: assert ((32'(offset) + 32'(k)) == 32'(N - 1))
        else $error("left offset does not complement shift amount");
  end

endmodule

// File: rtl/fsh_mux_stage.sv
module fsh_mux_stage #(
  parameter int IN_W = 63,
  parameter int SH   = 1,
  parameter int OW   = IN_W - SH
) (
  input  logic [IN_W-1:0] din,
  input  logic            sel,
  output logic [OW-1:0]   dout
);
  assign dout = sel ? din[IN_W-1:SH] : din[OW-1:0];
endmodule

// File: rtl/fsh_funnel.sv
module fsh_funnel #(
  parameter int N = 32,
  localparam int KW = $clog2(N),
  localparam int ZW = 2*N - 1
) (
  input  logic [N-1:0]  a_in,
  input  logic [KW-1:0] shamt,
  input  logic [2:0]    mode,
  output logic [N-1:0]  y_out
);
  import fsh_pkg::*;

  logic [ZW-1:0] z_word;
  logic [KW-1:0] win_off;

  fsh_zbuild #(.N(N), .KW(KW)) u_zb (
    .a      (a_in),
    .k      (shamt),
    .mode   (mode),
    .z      (z_word),
    .offset (win_off)
  );

  // log2(N) stages; stage s drops 2**s bits, total drop N-1 leaves N bits
  for (genvar s = 0; s < KW; s++) begin : stg
    localparam int IW = ZW - ((1 << s) - 1);
    localparam int OW = IW - (1 << s);
    logic [IW-1:0] din;
    logic [OW-1:0] dout;
    if (s == 0) begin : g_first
      assign din = z_word;
    end else begin : g_next
      assign din = stg[s-1].dout;
    end
    fsh_mux_stage #(.IN_W(IW), .SH(1 << s)) u_m (
      .din  (din),
      .sel  (win_off[s]),
      .dout (dout)
    );
  end

  assign y_out = stg[KW-1].dout;

  always_comb begin
    if (shamt == '0)
      assert_zero_shift_R7: assert (y_out == a_in)
        else $error("zero shift altered operand");
    if (!fsh_is_defined(mode))
      assert_undefined_pass_R8: assert (y_out == a_in)
        else $error("undefined mode altered operand");
    if (mode == FSH_ASR)
      assert_sign_kept_R3: assert (y_out[N-1] == a_in[N-1])
        else $error("arithmetic right lost sign");
    if (mode == FSH_LSR && shamt != '0)
      assert_top_zero_R1: assert (y_out[N-1] == 1'b0)
        else $error("logical right top bit not zero");
    if (fsh_is_left(mode) && !fsh_is_rotate(mode) && shamt != '0)
      assert_bottom_zero_R2: assert (y_out[0] == 1'b0)
        else $error("left shift bottom bit not zero");
    if (fsh_is_rotate(mode))
      assert_ones_kept_R9: assert ($countones(y_out) == $countones(a_in))
        else $error("rotate changed population count");
  end

endmodule

// File: tb/sim_fsh_funnel.sv
module sim_fsh_funnel;
  localparam int N  = 32;
  localparam int KW = $clog2(N);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]  a_in;
  logic [KW-1:0] shamt;
  logic [2:0]    mode;
  logic [N-1:0]  y_out;

  fsh_funnel #(.N(N)) u0 (.a_in(a_in), .shamt(shamt), .mode(mode), .y_out(y_out));

  typedef struct {
    logic [N-1:0] exp_y;
    logic [N-1:0] a;
    int           k;
    logic [2:0]   m;
    string        tag;
  } item_t;

  item_t sb_q[$];
  int n_checks = 0;
  int n_errors = 0;
  bit driving_done = 1'b0;

  // independent reference built from language operators
  function automatic logic [N-1:0] ref_shift(input logic [N-1:0] a, input int k, input logic [2:0] m);
    logic [2*N-1:0] dbl;
    dbl = {a, a};
    case (m)
      3'b000: return a >> k;
      3'b001: return a << k;
      3'b010: return $unsigned($signed(a) >>> k);
      3'b011: return a << k;
      3'b100: return dbl[N-1:0] >> k | (k == 0 ? '0 : a << (N - k));
      3'b101: return (a << k) | (k == 0 ? '0 : a >> (N - k));
      default: return a;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] m, input int k);
    if (k == 0) return "R7";
    case (m)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(input logic [N-1:0] a, input int k, input logic [2:0] m);
    item_t it;
    @(posedge clk);
    #1;
    a_in  = a;
    shamt = KW'(k);
    mode  = m;
    it.exp_y = ref_shift(a, k, m);
    it.a = a; it.k = k; it.m = m;
    it.tag = tag_of(m, k);
    sb_q.push_back(it);
  endtask

  // monitor: sample mid-cycle, same cycle as the drive (R10)
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (y_out !== it.exp_y) begin
        n_errors++;
        $display("FAIL %s (R10 same-cycle) mode=%0d k=%0d a=%h actual=%h expected=%h",
                 it.tag, it.m, it.k, it.a, y_out, it.exp_y);
      end
      if (it.m == 3'b100 || it.m == 3'b101) begin
        n_checks++;
        if ($countones(y_out) != $countones(it.a)) begin
          n_errors++;
          $display("FAIL R9 mode=%0d k=%0d actual=%0d expected=%0d",
                   it.m, it.k, $countones(y_out), $countones(it.a));
        end
      end
    end
  end

  logic [N-1:0] pats[10];

  initial begin
    a_in = '0; shamt = '0; mode = '0;
    #1;
    n_checks++;
    if (y_out !== '0) begin
      n_errors++;
      $display("FAIL R7 initial zero inputs actual=%h expected=%h", y_out, {N{1'b0}});
    end
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = {1'b1, {(N-1){1'b0}}};
    pats[3] = {{(N-1){1'b0}}, 1'b1};
    pats[4] = {1'b0, {(N-1){1'b1}}};
    pats[5] = {(N/2){2'b10}};
    pats[6] = {(N/2){2'b01}};
    for (int r = 7; r < 10; r++) pats[r] = N'({$urandom, $urandom});
    for (int p = 0; p < 10; p++)
      for (int m = 0; m < 8; m++)
        for (int k = 0; k < N; k++)
          drive(pats[p], k, 3'(m));
    // R4: arithmetic left matches logical left on negative operands too
    for (int k = 0; k < N; k++) drive(N'({$urandom, $urandom}) | pats[2], k, 3'b011);
    @(posedge clk);
    @(posedge clk);
    driving_done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (driving_done);
      end
      begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule